// File: doc/BRIEF.md
# Staged Clock Divider Bank

This block keeps a bank of seven programmable integer clock dividers that feed the consumers of a display output path: the analog VGA port, the picture pipeline, the TV encoder, the HDMI pixel path, the HDMI core, the output interface and the layer engine. All dividers run from one shared source clock enable. Each produces its own enable pulse train at the source rate divided by its programmed ratio.

Software first clears a commit flag. It then writes new 3-bit ratios into staging fields, naming each target by a divider identifier. Setting the flag again moves every staged ratio into the live dividers at once, so the outputs never run with half of an old setting and half of a new one. Dividers 0 and 1 make up the clock-select group and dividers 2 to 6 make up the divider-parameter group. The two groups share the single commit flag.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset every live and staged ratio is zero and the commit flag is clear, so each bit of `div_ce` equals `src_ce`.
- R2: A field write with `fld_id` 0 to 6 stores `fld_val` as the staged ratio of divider `fld_id`. Bit i of `div_ce` belongs to divider i (0 VGA, 1 picture, 2 TV encoder, 3 HDMI pixel, 4 HDMI, 5 interface, 6 layer).
- R3: A field write with `fld_id` equal to 7 changes no staged ratio.
- R4: A write of 1 to the commit flag while it is clear copies all seven staged ratios into the live dividers in the same cycle. A staged write in that same cycle is not part of the commit.
- R5: A write of 1 while the flag is already set commits nothing.
- R6: A live ratio N makes divider i pulse on every (N+1)-th cycle in which `src_ce` is high. Cycles with `src_ce` low do not advance the count, and a ratio of 0 passes `src_ce` straight through.
- R7: In the cycle after a commit, every divider count restarts at zero. The first pulse after a commit therefore comes on the (N+1)-th `src_ce` cycle.
- R8: `div_ce` is all zero in any cycle with `src_ce` low.
- R9: Between commits, the live ratios keep their values regardless of staged writes or writes of 0 to the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| src_ce | input | 1 | Shared source clock enable |
| fld_we | input | 1 | Staged field write strobe |
| fld_id | input | 3 | Target divider identifier (7 is unknown) |
| fld_val | input | 3 | Ratio value to stage |
| upd_we | input | 1 | Commit flag write strobe |
| upd_val | input | 1 | Value written to the commit flag |
| div_ce | output | 7 | Per-divider enable pulses, bit i = divider i |

## Verification
The hardest case to reach from the ports combines three events: a commit, a staged write in the same cycle, and a count left midway through a long ratio. Only that mix shows whether the commit is atomic and whether the count restart takes priority over counting. The random phase therefore raises the field write strobe often and toggles the commit flag rarely, on uneven `src_ce` patterns, so that commits land mid-count and collide with writes. Directed sequences add the repeated set of the flag and the unknown identifier.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int NUM_DIV = 7;
    localparam int VAL_W   = 3;
    localparam int ID_W    = 3;

    typedef logic [VAL_W-1:0] div_val_t;

    typedef enum logic [ID_W-1:0] {
        DIV_VGA      = 3'd0,
        DIV_PIC      = 3'd1,
        DIV_TVENC    = 3'd2,
        DIV_HDMI_PIX = 3'd3,
        DIV_HDMI     = 3'd4,
        DIV_IFACE    = 3'd5,
        DIV_LAYER    = 3'd6
    } div_id_e;

    typedef struct packed {
        logic           we;
        logic [ID_W-1:0] id;
        div_val_t       val;
    } fld_wr_t;

    function automatic logic id_known(input logic [ID_W-1:0] id);
        return int'(id) < NUM_DIV;
    endfunction
endpackage

// File: rtl/clkdiv_stage.sv
module clkdiv_stage
    import clkdiv_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  fld_wr_t                       wr,
    input  logic                          upd_we,
    input  logic                          upd_val,
    output logic [NUM_DIV-1:0][VAL_W-1:0] staged,
    output logic                          commit
);
    logic flag_q;

    assign commit = upd_we && upd_val && !flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (upd_we) begin
            flag_q <= upd_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            staged <= '0;
        end else if (wr.we && id_known(wr.id)) begin
            staged[wr.id] <= wr.val;
        end
    end

    AST_UNKNOWN_ID_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr.we && !id_known(wr.id)) |=> $stable(staged)); // R3

    AST_NO_REPEAT_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (upd_we && upd_val) |=> !commit); // R5
endmodule

// File: rtl/clkdiv_cell.sv
module clkdiv_cell
    import clkdiv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     src_ce,
    input  logic     commit,
    input  div_val_t staged_val,
    output logic     ce_out
);
    div_val_t live_q;
    div_val_t cnt_q;
    logic     wrap;

    assign wrap   = (cnt_q == live_q);
    assign ce_out = src_ce && wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
            cnt_q  <= '0;
        end else if (commit) begin
            live_q <= staged_val;
            cnt_q  <= '0;
        end else if (src_ce) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= live_q); // R6

    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
        (live_q == '0 && src_ce) |-> ce_out); // R6

    AST_RESTART: assert property (@(posedge clk) disable iff (rst)
        commit |=> (cnt_q == '0)); // R7

    AST_HOLD_LIVE: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(live_q)); // R9
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
    import clkdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               src_ce,
    input  logic               fld_we,
    input  logic [ID_W-1:0]    fld_id,
    input  logic [VAL_W-1:0]   fld_val,
    input  logic               upd_we,
    input  logic               upd_val,
    output logic [NUM_DIV-1:0] div_ce
);
    fld_wr_t                       wr;
    logic [NUM_DIV-1:0][VAL_W-1:0] staged;
    logic                          commit;

    assign wr = '{we: fld_we, id: fld_id, val: fld_val};

    clkdiv_stage u_stage (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .upd_we  (upd_we),
        .upd_val (upd_val),
        .staged  (staged),
        .commit  (commit)
    );

    for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
        clkdiv_cell u_cell (
            .clk        (clk),
            .rst        (rst),
            .src_ce     (src_ce),
            .commit     (commit),
            .staged_val (staged[i]),
            .ce_out     (div_ce[i])
        );
    end

    AST_GATED_BY_SRC: assert property (@(posedge clk) disable iff (rst)
        !src_ce |-> (div_ce == '0)); // R8
endmodule

// File: tb/tb_clkdiv_bank.sv
module tb_clkdiv_bank;
    localparam int N = 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       src_ce = 1'b0;
    logic       fld_we = 1'b0;
    logic [2:0] fld_id = '0;
    logic [2:0] fld_val = '0;
    logic       upd_we = 1'b0;
    logic       upd_val = 1'b0;
    logic [N-1:0] div_ce;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [2:0] stage_m [N];
    logic [2:0] live_m  [N];
    logic [2:0] cnt_m   [N];
    logic       flag_m;

    clkdiv_bank dut (
        .clk(clk), .rst(rst), .src_ce(src_ce), .fld_we(fld_we),
        .fld_id(fld_id), .fld_val(fld_val), .upd_we(upd_we),
        .upd_val(upd_val), .div_ce(div_ce)
    );

    always #2.5 clk = ~clk;

    function automatic logic [N-1:0] expect_ce();
        logic [N-1:0] e;
        for (int i = 0; i < N; i++) e[i] = src_ce && (cnt_m[i] == live_m[i]);
        return e;
    endfunction

    task automatic model_clock();
        logic commit;
        commit = upd_we && upd_val && !flag_m;
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                stage_m[i] = '0; live_m[i] = '0; cnt_m[i] = '0;
            end
            flag_m = 1'b0;
            return;
        end
        for (int i = 0; i < N; i++) begin
            if (commit) begin
                live_m[i] = stage_m[i];
                cnt_m[i]  = '0;
            end else if (src_ce) begin
                cnt_m[i] = (cnt_m[i] == live_m[i]) ? 3'd0 : cnt_m[i] + 3'd1;
            end
        end
        if (fld_we && fld_id < 3'd7) stage_m[fld_id] = fld_val;
        if (upd_we) flag_m = upd_val;
    endtask

    // Inputs are already applied at the falling edge; check, then advance.
    task automatic step(input string tag);
        logic [N-1:0] e;
        #1;
        if (!rst) begin
            e = expect_ce();
            checks++;
            if (div_ce !== e) begin
                errors++;
                $display("FAIL %s: div_ce actual %b expected %b", tag, div_ce, e);
            end
        end
        model_clock();
        @(posedge clk);
        @(negedge clk);
        fld_we = 1'b0;
        upd_we = 1'b0;
    endtask

    task automatic wr_field(input logic [2:0] id, input logic [2:0] v,
                            input logic ce, input string tag);
        fld_we = 1'b1; fld_id = id; fld_val = v; src_ce = ce;
        step(tag);
    endtask

    task automatic wr_flag(input logic v, input logic ce, input string tag);
        upd_we = 1'b1; upd_val = v; src_ce = ce;
        step(tag);
    endtask

    task automatic run(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            src_ce = (k % 3 != 2);
            step(tag);
        end
    endtask

    initial begin
        #(5 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < N; i++) begin
            stage_m[i] = '0; live_m[i] = '0; cnt_m[i] = '0;
        end
        flag_m = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        step("reset"); step("reset"); step("reset");
        rst = 1'b0;

        // R1: pass-through after reset; R8: gated by src_ce
        src_ce = 1'b1; step("R1");
        src_ce = 1'b0; step("R8");
        src_ce = 1'b1; step("R1");

        // R2, R9: stage ratios with flag clear, outputs keep old ratios
        wr_flag(1'b0, 1'b1, "R9");
        for (int i = 0; i < N; i++) wr_field(3'(i), 3'(i), (i % 2) == 0, "R2");
        // R3: unknown id ignored
        wr_field(3'd7, 3'd5, 1'b1, "R3");
        run(5, "R9");
        // R4 with a same-cycle staged write excluded from commit
        fld_we = 1'b1; fld_id = 3'd6; fld_val = 3'd2;
        wr_flag(1'b1, 1'b1, "R4");
        // R7, R6: restart and periodic pulses
        run(40, "R7");
        run(40, "R6");
        // R5: second set with new staged values does not commit
        wr_field(3'd0, 3'd7, 1'b1, "R5");
        wr_flag(1'b1, 1'b1, "R5");
        run(20, "R5");
        // R4: clear then set commits
        wr_flag(1'b0, 1'b0, "R4");
        wr_field(3'd3, 3'd1, 1'b1, "R4");
        wr_flag(1'b1, 1'b1, "R4");
        run(30, "R6");

        // Constrained random mix
        for (int k = 0; k < 4000; k++) begin
            src_ce  = ($urandom % 4) != 0;
            fld_we  = ($urandom % 3) == 0;
            fld_id  = 3'($urandom % 8);
            fld_val = 3'($urandom);
            upd_we  = ($urandom % 12) == 0;
            upd_val = 1'($urandom);
            step("R6");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule